// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides its clock by a programmable ratio N, which is read as a word of an upper count M and a lower count A. A dual-modulus stage counts either 2^A_W + 1 or 2^A_W clock ticks per sub-cycle. A swallow counter keeps the long modulus for the first A sub-cycles of every M-sub-cycle frame and the short modulus for the rest, so one frame lasts 16·M + A ticks when A_W is 4. At the end of each frame the block emits a one-clock pulse toward a phase comparator. It also toggles a half-rate output that test logic can route to a pin.

A static enable inserts a divide-by-two ahead of the chain, which doubles the overall ratio. A new ratio is captured on a load strobe into a shadow register. The running counters take it up only at the next frame boundary, so a frame in progress always completes with the ratio it started with. The structure needs M ≥ A, so the smallest legal ratio is 2^A_W·(2^A_W − 1), which is 240 for the default widths. A smaller value is raised to that minimum and sets a sticky error flag. All pins are plain control or status lines. The output is a pulse with no handshake, and nothing at the edge of the block can stall.

Top module: `psw_divider`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `div_pulse_o`, `div_half_o` and `clamp_err_o` are 0. Until the first load, the block divides by the minimum ratio (240 for the default widths).
- R2: With `pre_en_i` = 0, consecutive `div_pulse_o` pulses are exactly N clock cycles apart, where N = 16·ratio[R_W-1:4] + ratio[3:0], for every N from 240 up to 2^R_W − 1.
- R3: Each dual-modulus sub-cycle lasts 2^A_W + 1 enabled ticks while the swallow count is nonzero, and 2^A_W ticks otherwise.
- R4: With `pre_en_i` = 1, which is held constant outside reset, consecutive pulses are exactly 2·N clock cycles apart.
- R5: `div_pulse_o` is high for exactly one clock cycle per frame.
- R6: `div_half_o` changes value on exactly the cycles when `div_pulse_o` is high and holds otherwise, so its period is twice the pulse spacing.
- R7: A ratio loaded at any point of a frame leaves that frame's length unchanged and governs the frame that follows.
- R8: Loading a ratio below the minimum stores the minimum and sets `clamp_err_o`, which then stays 1 until reset.
- R9: `ratio_i` has no effect while `load_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| ratio_i | input | R_W (17) | Division ratio: upper M_W bits are M, lower A_W bits are A |
| pre_en_i | input | 1 | Static enable of the divide-by-two front stage |
| load_i | input | 1 | Captures `ratio_i` into the shadow register |
| div_pulse_o | output | 1 | One-cycle pulse at each frame end |
| div_half_o | output | 1 | Output toggled on every pulse |
| clamp_err_o | output | 1 | Sticky flag: a ratio below the minimum was loaded |

## Verification
The hardest case to reach is a reload that arrives while a frame is in flight, and above all one that arrives right at a boundary. A mix-up between shadow and live counters shows up only one frame later. The bench therefore chains the loads: it writes a new ratio on the cycle after each pulse and checks each measured spacing against the ratio written one frame earlier. It sweeps every ratio from 240 to 511, plus edge values with A at 0 and at 15, in a reduced-width configuration. A separate load in the middle of a frame confirms that the frame being counted keeps its old length.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int unsigned PSW_M_W = 13;
  localparam int unsigned PSW_A_W = 4;

  typedef enum logic {
    MOD_SHORT = 1'b0,
    MOD_LONG  = 1'b1
  } mod_sel_e;
endpackage

// File: rtl/psw_prescale.sv
module psw_prescale (
  input  logic clk,
  input  logic rst,
  input  logic pre_en_i,
  output logic tick_o
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= 1'b0;
    else     phase_q <= ~phase_q;
  end

  assign tick_o = ~pre_en_i | phase_q;
endmodule

// File: rtl/psw_dual_mod.sv
module psw_dual_mod
  import psw_pkg::*;
#(
  parameter int unsigned A_W = PSW_A_W
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick_i,
  input  mod_sel_e mod_sel_i,
  output logic     wrap_o
);
  localparam logic [A_W:0] LIM_LONG  = {1'b1, {A_W{1'b0}}};
  localparam logic [A_W:0] LIM_SHORT = {1'b0, {A_W{1'b1}}};

  logic [A_W:0] cnt_q;
  logic [A_W:0] limit;

  always_comb begin
    case (mod_sel_i)
      MOD_LONG: limit = LIM_LONG;
      default:  limit = LIM_SHORT;
    endcase
  end

  assign wrap_o = tick_i && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/psw_swallow.sv
module psw_swallow #(
  parameter int unsigned M_W   = 13,
  parameter int unsigned A_W   = 4,
  parameter int unsigned M_RST = 15,
  parameter int unsigned A_RST = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wrap_i,
  input  logic [M_W-1:0] m_load_i,
  input  logic [A_W-1:0] a_load_i,
  output logic           a_nz_o,
  output logic           term_o
);
  logic [M_W-1:0] m_left_q;
  logic [A_W-1:0] a_left_q;

  assign a_nz_o = (a_left_q != '0);
  assign term_o = wrap_i && (m_left_q == M_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      m_left_q <= M_W'(M_RST);
      a_left_q <= A_W'(A_RST);
    end else if (term_o) begin
      m_left_q <= m_load_i;
      a_left_q <= a_load_i;
    end else if (wrap_i) begin
      m_left_q <= m_left_q - 1'b1;
      if (a_nz_o) a_left_q <= a_left_q - 1'b1;
    end
  end
endmodule

// File: rtl/psw_ratio_shadow.sv
module psw_ratio_shadow #(
  parameter int unsigned R_W = 17,
  parameter int unsigned MIN = 240
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_i,
  input  logic [R_W-1:0] ratio_i,
  output logic [R_W-1:0] ratio_o,
  output logic           err_o
);
  localparam logic [R_W-1:0] MIN_V = R_W'(MIN);

  logic too_small;
  assign too_small = (ratio_i < MIN_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_o <= MIN_V;
      err_o   <= 1'b0;
    end else if (load_i) begin
      ratio_o <= too_small ? MIN_V : ratio_i;
      if (too_small) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/psw_divider.sv
module psw_divider
  import psw_pkg::*;
#(
  parameter int unsigned M_W = PSW_M_W,
  parameter int unsigned A_W = PSW_A_W,
  localparam int unsigned R_W = M_W + A_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [R_W-1:0] ratio_i,
  input  logic           pre_en_i,
  input  logic           load_i,
  output logic           div_pulse_o,
  output logic           div_half_o,
  output logic           clamp_err_o
);
  localparam int unsigned MOD_BASE  = 2 ** A_W;
  localparam int unsigned MIN_RATIO = MOD_BASE * (MOD_BASE - 1);

  logic           tick;
  logic           mod_wrap;
  logic           a_nz;
  logic           term;
  logic [R_W-1:0] shadow_ratio;
  mod_sel_e       mod_sel;

  psw_ratio_shadow #(.R_W(R_W), .MIN(MIN_RATIO)) u_shadow (
    .clk(clk), .rst(rst), .load_i(load_i), .ratio_i(ratio_i),
    .ratio_o(shadow_ratio), .err_o(clamp_err_o)
  );

  psw_prescale u_pre (
    .clk(clk), .rst(rst), .pre_en_i(pre_en_i), .tick_o(tick)
  );

  assign mod_sel = a_nz ? MOD_LONG : MOD_SHORT;

  psw_dual_mod #(.A_W(A_W)) u_mod (
    .clk(clk), .rst(rst), .tick_i(tick), .mod_sel_i(mod_sel), .wrap_o(mod_wrap)
  );

  psw_swallow #(.M_W(M_W), .A_W(A_W), .M_RST(MOD_BASE - 1), .A_RST(0)) u_swl (
    .clk(clk), .rst(rst), .wrap_i(mod_wrap),
    .m_load_i(shadow_ratio[R_W-1:A_W]), .a_load_i(shadow_ratio[A_W-1:0]),
    .a_nz_o(a_nz), .term_o(term)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div_pulse_o <= 1'b0;
      div_half_o  <= 1'b0;
    end else begin
      div_pulse_o <= term;
      if (term) div_half_o <= ~div_half_o;
    end
  end
endmodule

// File: rtl/psw_divider_chk.sv
module psw_divider_chk #(
  parameter int unsigned A_W = 4,
  parameter int unsigned R_W = 17
) (
  input logic           clk,
  input logic           rst,
  input logic           load_i,
  input logic [R_W-1:0] ratio_i,
  input logic           div_pulse_o,
  input logic           div_half_o,
  input logic           clamp_err_o,
  input logic           tick,
  input logic           wrap,
  input logic           swallow_nz,
  input logic [R_W-1:0] shadow
);
  localparam int unsigned MOD_BASE  = 2 ** A_W;
  localparam int unsigned MIN_RATIO = MOD_BASE * (MOD_BASE - 1);

  logic [A_W+1:0] ticks_q;
  always_ff @(posedge clk) begin
    if (rst)       ticks_q <= '0;
    else if (wrap) ticks_q <= '0;
    else if (tick) ticks_q <= ticks_q + 1'b1;
  end

  // R3
  long_mod_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap && swallow_nz) |-> (ticks_q == (A_W+2)'(MOD_BASE)));
  // R3
  short_mod_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap && !swallow_nz) |-> (ticks_q == (A_W+2)'(MOD_BASE - 1)));
  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    div_pulse_o |=> !div_pulse_o);
  // R6
  half_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(div_pulse_o) |-> (div_half_o != $past(div_half_o)));
  // R6
  half_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !div_pulse_o |-> $stable(div_half_o));
  // R8
  clamp_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && (ratio_i < R_W'(MIN_RATIO))) |=> clamp_err_o);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    clamp_err_o |=> clamp_err_o);
  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(shadow));
endmodule

bind psw_divider psw_divider_chk #(.A_W(A_W), .R_W(R_W)) u_chk (
  .clk(clk), .rst(rst), .load_i(load_i), .ratio_i(ratio_i),
  .div_pulse_o(div_pulse_o), .div_half_o(div_half_o), .clamp_err_o(clamp_err_o),
  .tick(tick), .wrap(mod_wrap), .swallow_nz(a_nz), .shadow(shadow_ratio)
);

// File: tb/psw_divider_tb.sv
module psw_divider_tb;
  localparam int M_W = 8;
  localparam int A_W = 4;
  localparam int R_W = M_W + A_W;
  localparam int MINR = 240;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst = 1'b1;
  logic [R_W-1:0] ratio = '0;
  logic           pre_en = 1'b0;
  logic           load = 1'b0;
  logic           div_pulse_o, div_half_o, clamp_err_o;

  psw_divider #(.M_W(M_W), .A_W(A_W)) u_dut (
    .clk(clk), .rst(rst), .ratio_i(ratio), .pre_en_i(pre_en), .load_i(load),
    .div_pulse_o(div_pulse_o), .div_half_o(div_half_o), .clamp_err_o(clamp_err_o)
  );

  longint cyc = 0;
  always @(posedge clk) cyc++;

  int     n_chk = 0;
  int     n_fail = 0;
  longint last_stamp = 0;
  logic   prev_half = 1'b0;
  int     last_ratio = MINR;
  int     mult = 1;
  longint iv;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic pe);
    rst = 1'b1; pre_en = pe; load = 1'b0;
    repeat (4) @(negedge clk);
    chk(div_pulse_o == 1'b0, "R1 pulse in reset", div_pulse_o, 0);
    chk(div_half_o == 1'b0, "R1 half in reset", div_half_o, 0);
    chk(clamp_err_o == 1'b0, "R1 err in reset", clamp_err_o, 0);
    rst = 1'b0;
    prev_half = 1'b0;
    last_ratio = MINR;
    mult = pe ? 2 : 1;
    @(negedge clk);
    chk(div_pulse_o == 1'b0 && div_half_o == 1'b0 && clamp_err_o == 1'b0,
        "R1 outputs after reset", {div_pulse_o, div_half_o, clamp_err_o}, 0);
  endtask

  task automatic wait_pulse(output longint ivl);
    do @(negedge clk); while (!div_pulse_o);
    ivl = cyc - last_stamp;
    last_stamp = cyc;
    chk(div_half_o != prev_half, "R6 half toggles at pulse", div_half_o, !prev_half);
    prev_half = div_half_o;
  endtask

  task automatic load_val(input int r);
    ratio = R_W'(r); load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk(div_pulse_o == 1'b0, "R5 pulse one cycle wide", div_pulse_o, 0);
  endtask

  // Called right after a pulse: frame now running uses last_ratio.
  task automatic run_seq(input int r, input string tag);
    longint ivl;
    load_val(r);
    wait_pulse(ivl);
    chk(ivl == longint'(last_ratio * mult), tag, ivl, last_ratio * mult);
    last_ratio = (r < MINR) ? MINR : r;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 190000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    wait_pulse(iv);
    wait_pulse(iv);
    chk(iv == MINR, "R1 default ratio", iv, MINR);

    // R9: ratio changes without load
    ratio = R_W'(1000);
    wait_pulse(iv);
    chk(iv == MINR, "R9 ratio ignored without load", iv, MINR);
    ratio = R_W'(300);
    wait_pulse(iv);
    chk(iv == MINR, "R9 ratio ignored without load", iv, MINR);

    // R2 / R7 chained sweep
    for (int r = 240; r <= 511; r++) run_seq(r, "R2 R7 sweep spacing");
    run_seq(3840, "R2 A=0");
    run_seq(3855, "R2 A=15");
    run_seq(4095, "R2 max");
    run_seq(4094, "R2 near max");
    run_seq(255, "R2 M=A");
    run_seq(255, "R2 flush");

    // R7: load in the middle of a frame
    repeat (50) @(negedge clk);
    load_val(600);
    wait_pulse(iv);
    chk(iv == 255, "R7 mid-frame load keeps old ratio", iv, 255);
    wait_pulse(iv);
    chk(iv == 600, "R7 new ratio next frame", iv, 600);
    last_ratio = 600;

    // R8 clamp and sticky flag
    chk(clamp_err_o == 1'b0, "R8 flag clear before", clamp_err_o, 0);
    run_seq(17, "R8 frame before clamp");
    chk(clamp_err_o == 1'b1, "R8 flag set", clamp_err_o, 1);
    run_seq(300, "R8 clamped to minimum");
    chk(clamp_err_o == 1'b1, "R8 flag sticky", clamp_err_o, 1);
    run_seq(0, "R8 legal ratio after clamp");
    run_seq(300, "R8 zero clamped");
    chk(clamp_err_o == 1'b1, "R8 flag still sticky", clamp_err_o, 1);

    // R4 prescaler enabled
    do_reset(1'b1);
    wait_pulse(iv);
    wait_pulse(iv);
    chk(iv == 2 * MINR, "R4 default doubled", iv, 2 * MINR);
    run_seq(241, "R4 doubled spacing");
    run_seq(255, "R4 doubled spacing");
    run_seq(256, "R4 doubled spacing");
    run_seq(700, "R4 doubled spacing");
    run_seq(4095, "R4 doubled spacing");
    run_seq(4095, "R4 doubled max");
    run_seq(240, "R4 doubled max repeat");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule